// File: doc/BRIEF.md
# Contact Card Power Sequencer

This block orders the power-up and power-down of a contact smart card. It runs on the card clock and drives four card-side controls: the supply enable, the I/O enable, the clock gate and the card reset line. On a start command it turns on the supply and waits for the supply-ready flag. It then enables I/O, starts the clock, waits a fixed settling time and then a programmable reset-hold window, and finally releases reset high.

A card-current fault aborts whatever is running and powers the card down in a fixed order. Reset goes low first, then the clock stops, then I/O is disabled, then the supply is removed, one card clock apart. A busy flag covers both sequences. A single-cycle done pulse marks a completed power-up. The reset-hold window is a 16-bit register that clamps every written value into its legal range.

Top module: `card_act_seq`

## Requirements
- R1: After synchronous reset, `card_pwr_en`, `card_io_en`, `card_clk_en`, `card_rst`, `busy` and `done` are all 0.
- R2: With the block idle, a sampled `start` sets `card_pwr_en` and `busy` at that edge. I/O, clock and reset stay low for as long as `supply_ok` is low.
- R3: In the edge where `supply_ok` is sampled high, `card_io_en` rises. `card_clk_en` rises on the next edge.
- R4: `card_rst` rises exactly `TA_CYC` + tc edges after the edge where `card_clk_en` rose. In that same edge `done` rises and `busy` falls.
- R5: The reset-hold value tc is 400 after reset.
- R6: A tc write below 400 is stored as 400.
- R7: A tc write above 40000 is stored as 40000. Values in range are stored unchanged.
- R8: A fault sampled while the card is active pulls `card_rst` low at that edge. `card_clk_en` falls one edge later, `card_io_en` two edges later, and `card_pwr_en` together with `busy` three edges later.
- R9: A fault sampled during power-up aborts it. No `done` pulse occurs, `card_rst` never rises, and the same power-down order follows.
- R10: While idle, `fault` has no effect. While the card is active, `start` has no effect.
- R11: `done` is high for exactly one cycle per completed power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin power-up when idle |
| supply_ok | input | 1 | Card supply has reached its level |
| fault | input | 1 | Card current fault |
| tc_wr | input | 1 | Write strobe for reset-hold value |
| tc_wdata | input | 16 | Reset-hold value in card clocks |
| card_pwr_en | output | 1 | Card supply enable |
| card_io_en | output | 1 | Card I/O enable (0 = I/O held low) |
| card_clk_en | output | 1 | Card clock gate (0 = clock stopped low) |
| card_rst | output | 1 | Card reset line |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse on completed power-up |

## Verification
Every output is a register, so each result shows up at the edge that samples its cause. `card_pwr_en` appears at the start edge and `card_io_en` at the supply-ready edge. `card_clk_en` follows one edge later, and `card_rst` follows `TA_CYC` + tc edges after that. The power-down steps land one, two and three edges after the fault edge. The bench drives inputs on the falling edge and samples 1 ns after each rising edge. For reset release it counts rising edges from the clock-start edge and compares the count to the expected sum. This also measures the clamped tc values, since tc is not visible at the ports.

// File: rtl/card_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding for the card power sequencer.
// Assumes: one sequencer per package user; encoding not decoded outside.
package card_seq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_WPWR   = 4'd1,
        ST_IO     = 4'd2,
        ST_CLK    = 4'd3,
        ST_RHOLD  = 4'd4,
        ST_ACTIVE = 4'd5,
        ST_DCLK   = 4'd6,
        ST_DIO    = 4'd7,
        ST_DPWR   = 4'd8
    } seq_state_t;

    // True for the power-down states, where a new fault changes nothing.
    function automatic logic is_down(seq_state_t s);
        return (s == ST_DCLK) || (s == ST_DIO) || (s == ST_DPWR);
    endfunction
endpackage

// File: rtl/tc_hold_reg.sv
`timescale 1ns/1ps
// Module: tc_hold_reg
// Holds the reset-hold window in card clocks. Every write is clamped to
// [LO, HI]. Assumes LO <= RST_VAL <= HI and HI fits in TW bits.
module tc_hold_reg #(
    parameter int TW      = 16,
    parameter int LO      = 400,
    parameter int HI      = 40000,
    parameter int RST_VAL = 400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [TW-1:0] wdata,
    output logic [TW-1:0] value
);
    localparam logic [TW-1:0] LoV = TW'(LO);
    localparam logic [TW-1:0] HiV = TW'(HI);
    localparam logic [TW-1:0] RsV = TW'(RST_VAL);

    logic [TW-1:0] clamped;

    // Limit the written value into the legal window.
    always_comb begin
        if (wdata < LoV)      clamped = LoV;
        else if (wdata > HiV) clamped = HiV;
        else                  clamped = wdata;
    end

    // Store the clamped value on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  value <= RsV;
        else if (wr) value <= clamped;
    end
endmodule

// File: rtl/seq_delay_timer.sv
`timescale 1ns/1ps
// Module: seq_delay_timer
// Down-counter for phase delays. A load of N-1 makes `zero` visible at the
// N-th edge after the load edge. The counter stops at zero.
module seq_delay_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    // Load, or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (load)          cnt <= load_val;
        else if (cnt != '0)     cnt <= cnt - CW'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/seq_ctrl_fsm.sv
`timescale 1ns/1ps
// Module: seq_ctrl_fsm
// Orders power-up (supply, I/O, clock, timed reset release) and power-down
// (reset, clock, I/O, supply). A fault has priority over any other step.
// Assumes tc >= 1 and TA >= 1. All outputs are registered.
module seq_ctrl_fsm
    import card_seq_pkg::*;
#(
    parameter int TW = 16,
    parameter int CW = 16,
    parameter int TA = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          supply_ok,
    input  logic          fault,
    input  logic [TW-1:0] tc,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          pwr_en,
    output logic          io_en,
    output logic          clk_en,
    output logic          rst_o,
    output logic          busy,
    output logic          done
);
    localparam logic [CW-1:0] TaM1 = CW'(TA - 1);

    seq_state_t st;
    logic       abort;

    assign abort = fault && (st != ST_IDLE) && !is_down(st);

    // Choose the timer reload for the next timed phase.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = TaM1;
        if (st == ST_IO) begin
            tmr_load = 1'b1;
        end else if (st == ST_CLK && tmr_zero) begin
            tmr_load = 1'b1;
            tmr_val  = CW'(tc - TW'(1));
        end
    end

    // Step the sequence and register the card-side controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            pwr_en <= 1'b0;
            io_en  <= 1'b0;
            clk_en <= 1'b0;
            rst_o  <= 1'b0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                rst_o <= 1'b0;
                busy  <= 1'b1;
                st    <= ST_DCLK;
            end else begin
                case (st)
                    ST_IDLE: if (start) begin
                        pwr_en <= 1'b1;
                        busy   <= 1'b1;
                        st     <= ST_WPWR;
                    end
                    ST_WPWR: if (supply_ok) begin
                        io_en <= 1'b1;
                        st    <= ST_IO;
                    end
                    ST_IO: begin
                        clk_en <= 1'b1;
                        st     <= ST_CLK;
                    end
                    ST_CLK: if (tmr_zero) st <= ST_RHOLD;
                    ST_RHOLD: if (tmr_zero) begin
                        rst_o <= 1'b1;
                        done  <= 1'b1;
                        busy  <= 1'b0;
                        st    <= ST_ACTIVE;
                    end
                    ST_ACTIVE: st <= ST_ACTIVE;
                    ST_DCLK: begin
                        clk_en <= 1'b0;
                        st     <= ST_DIO;
                    end
                    ST_DIO: begin
                        io_en <= 1'b0;
                        st    <= ST_DPWR;
                    end
                    ST_DPWR: begin
                        pwr_en <= 1'b0;
                        busy   <= 1'b0;
                        st     <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/card_act_seq.sv
`timescale 1ns/1ps
// Module: card_act_seq (top)
// Contact card power sequencer. It joins the clamped reset-hold register,
// the phase timer and the control FSM. Runs entirely on the card clock.
// Assumes TC_MIN >= 1 and TC_MAX < 2**TW.
module card_act_seq #(
    parameter int TW      = 16,
    parameter int TA_CYC  = 200,
    parameter int TC_MIN  = 400,
    parameter int TC_MAX  = 40000,
    parameter int TC_INIT = 400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          supply_ok,
    input  logic          fault,
    input  logic          tc_wr,
    input  logic [TW-1:0] tc_wdata,
    output logic          card_pwr_en,
    output logic          card_io_en,
    output logic          card_clk_en,
    output logic          card_rst,
    output logic          busy,
    output logic          done
);
    localparam int MaxDly = (TC_MAX > TA_CYC) ? TC_MAX : TA_CYC;
    localparam int CW     = $clog2(MaxDly + 1);

    logic [TW-1:0] tc_val;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;

    tc_hold_reg #(
        .TW(TW), .LO(TC_MIN), .HI(TC_MAX), .RST_VAL(TC_INIT)
    ) u_tc (
        .clk(clk), .rst_n(rst_n), .wr(tc_wr), .wdata(tc_wdata), .value(tc_val)
    );

    seq_delay_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .zero(tmr_zero)
    );

    seq_ctrl_fsm #(.TW(TW), .CW(CW), .TA(TA_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .supply_ok(supply_ok),
        .fault(fault), .tc(tc_val), .tmr_zero(tmr_zero),
        .tmr_load(tmr_load), .tmr_val(tmr_val),
        .pwr_en(card_pwr_en), .io_en(card_io_en), .clk_en(card_clk_en),
        .rst_o(card_rst), .busy(busy), .done(done)
    );
endmodule

// File: rtl/card_act_seq_chk.sv
`timescale 1ns/1ps
// Module: card_act_seq_chk
// Port-level protocol checks for card_act_seq. Attached by bind below.
module card_act_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic fault,
    input logic card_pwr_en,
    input logic card_io_en,
    input logic card_clk_en,
    input logic card_rst,
    input logic done
);
    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    rst_rise_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst) |-> done);

    // R9
    rst_rise_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst) |-> !$past(fault));

    // R8
    clk_stop_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_clk_en) |-> !card_rst);

    // R8
    io_off_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_io_en) |-> !card_clk_en);

    // R8
    pwr_off_after_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_pwr_en) |-> !card_io_en);

    // R2
    io_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_io_en |-> card_pwr_en);

    // R3
    clk_needs_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_clk_en |-> card_io_en);
endmodule

bind card_act_seq card_act_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fault(fault),
    .card_pwr_en(card_pwr_en), .card_io_en(card_io_en),
    .card_clk_en(card_clk_en), .card_rst(card_rst), .done(done)
);

// File: tb/sim_card_act_seq.sv
`timescale 1ns/1ps
// Directed bench for card_act_seq: one task per scenario.
module sim_card_act_seq;
    localparam int TA = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        supply_ok = 1'b0;
    logic        fault = 1'b0;
    logic        tc_wr = 1'b0;
    logic [15:0] tc_wdata = '0;
    logic        card_pwr_en, card_io_en, card_clk_en, card_rst, busy, done;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    card_act_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .supply_ok(supply_ok),
        .fault(fault), .tc_wr(tc_wr), .tc_wdata(tc_wdata),
        .card_pwr_en(card_pwr_en), .card_io_en(card_io_en),
        .card_clk_en(card_clk_en), .card_rst(card_rst),
        .busy(busy), .done(done)
    );

    // Advance past the next rising edge and settle.
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic drive_fall();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [5:0] outs();
        return {card_pwr_en, card_io_en, card_clk_en, card_rst, busy, done};
    endfunction

    task automatic write_tc(logic [15:0] v);
        drive_fall(); tc_wr = 1'b1; tc_wdata = v;
        drive_fall(); tc_wr = 1'b0;
    endtask

    // Full power-up; expects reset release TA+exp_tc edges after clock start.
    task automatic run_powerup(int exp_tc, string req);
        int rise_at;
        drive_fall(); start = 1'b1;
        tick();
        chk("R2", outs(), 6'b100010);
        drive_fall(); start = 1'b0;
        for (int i = 0; i < 3; i++) tick();
        chk("R2", outs(), 6'b100010);
        drive_fall(); supply_ok = 1'b1;
        tick();
        chk("R3", outs(), 6'b110010);
        tick();
        chk("R3", outs(), 6'b111010);
        rise_at = -1;
        for (int n = 1; n <= TA + exp_tc + 5; n++) begin
            tick();
            if (card_rst && rise_at < 0) begin
                rise_at = n;
                chk("R4", outs(), 6'b111101);
            end
            if (rise_at >= 0) break;
        end
        checks++;
        if (rise_at != TA + exp_tc) begin
            fails++;
            $display("FAIL %s reset-release edge actual=%0d expected=%0d",
                     req, rise_at, TA + exp_tc);
        end
        tick();
        chk("R11", outs(), 6'b111100);
    endtask

    // Raise a fault and check the four power-down steps from full-on state.
    task automatic run_powerdown(logic [5:0] first, string req);
        drive_fall(); fault = 1'b1;
        tick();
        chk(req, outs(), first);
        drive_fall(); fault = 1'b0;
        tick();
        chk(req, outs(), {first[5:4], 1'b0, 3'b010});
        tick();
        chk(req, outs(), {first[5], 5'b00010});
        tick();
        chk(req, outs(), 6'b000000);
        drive_fall(); supply_ok = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) tick();
        chk("R1", outs(), 6'b000000);
        drive_fall(); rst_n = 1'b1;
        tick();
        chk("R1", outs(), 6'b000000);
    endtask

    task automatic t_idle_fault();
        drive_fall(); fault = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R10", outs(), 6'b000000);
        end
        drive_fall(); fault = 1'b0;
    endtask

    task automatic t_active_start();
        drive_fall(); start = 1'b1;
        tick();
        drive_fall(); start = 1'b0;
        tick(); tick();
        chk("R10", outs(), 6'b111100);
    endtask

    task automatic t_abort_clk();
        int seen_done = 0;
        drive_fall(); start = 1'b1;
        tick();
        drive_fall(); start = 1'b0; supply_ok = 1'b1;
        tick(); tick();
        for (int i = 0; i < 50; i++) begin
            tick();
            if (done || card_rst) seen_done++;
        end
        chk("R9", outs(), 6'b111010);
        run_powerdown(6'b111010, "R9");
        for (int i = 0; i < TA + 500; i++) begin
            tick();
            if (done || card_rst) seen_done++;
        end
        checks++;
        if (seen_done != 0) begin
            fails++;
            $display("FAIL R9 done/reset seen actual=%0d expected=0", seen_done);
        end
    endtask

    task automatic t_abort_wpwr();
        drive_fall(); start = 1'b1;
        tick();
        drive_fall(); start = 1'b0;
        tick();
        drive_fall(); fault = 1'b1;
        tick();
        chk("R9", outs(), 6'b100010);
        drive_fall(); fault = 1'b0;
        tick(); tick();
        chk("R9", outs(), 6'b100010);
        tick();
        chk("R9", outs(), 6'b000000);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        t_reset();
        t_idle_fault();
        run_powerup(400, "R5");
        t_active_start();
        run_powerdown(6'b111010, "R8");
        write_tc(16'd1000);
        run_powerup(1000, "R7");
        run_powerdown(6'b111010, "R8");
        write_tc(16'd100);
        run_powerup(400, "R6");
        run_powerdown(6'b111010, "R8");
        t_abort_clk();
        t_abort_wpwr();
        write_tc(16'd50000);
        run_powerup(40000, "R7");
        run_powerdown(6'b111010, "R8");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule